// File: doc/BRIEF.md
# Asynchronous Exception Priority Arbiter

This block watches a fixed set of asynchronous exception sources and, at most once per clock, grants the most urgent one. The sources are a system-reset request, a group of machine-check sources (non-maskable interrupt pin, machine-check pin, cache parity error, bus error), and six maskable sources: debug, critical input, watchdog, external input, fixed-interval timer and decrementer. A rising edge on a source latches a pending bit. Each clock, the highest-ranked eligible pending bit wins. The block then emits a one-cycle take pulse, a 3-bit cause code and a 32-bit handler address, and clears the winner's pending bit.

Reset and machine check are non-maskable. They join arbitration as soon as they are pending, whether or not a handler is already running. A maskable source joins only when two things hold: its enable bit is set, and the core reports that it has reached a recoverable state. Until then its pending bit waits, and software can clear it through a per-source cancel line.

The handler address is built from two registers. The upper half comes from a prefix register. The next twelve bits come from one of sixteen offset registers, picked per cause through a fixed index map. The low nibble is zero. The block saves no context and does not steer the program counter; it only reports the decision.

Top module: `async_exc_arbiter`

## Requirements
- R1: A pending system reset (cause 0) wins over every other pending source, ignores `recovOk` and all enables, and is reported with `vecAddr` equal to zero.
- R2: Cause codes rank highest first as: 0 reset, 1 machine check, 2 debug, 3 critical, 4 watchdog, 5 external, 6 fixed-interval timer, 7 decrementer. At most one take occurs per cycle, so a set of eligible pending sources is reported on consecutive cycles in ascending cause order.
- R3: A rising edge on any bit of `mcSrc` makes machine check (cause 1) pending, and it is taken without waiting for `recovOk`.
- R4: For causes 1 to 7, `vecAddr[31:16]` is prefix bits 31:16, `vecAddr[15:4]` is bits 15:4 of the offset register selected for the cause, and `vecAddr[3:0]` is zero. The offset index per cause is: machine check 1, debug 15, critical 0, watchdog 12, external 4, fixed-interval timer 11, decrementer 10.
- R5: A maskable source (cause 2+k, bit k of `maskReq`/`maskEn`/`cancelReq`, k = 0 debug up to k = 5 decrementer) is taken only in a cycle where `maskEn[k]` and `recovOk` are both high.
- R6: A maskable source that has been requested but is not eligible stays pending. It is taken once its enable and `recovOk` are both high.
- R7: A high `cancelReq[k]` clears the pending bit of cause 2+k, so that the source is not taken when it becomes eligible later.
- R8: Pending bits are set on request edges only: a request held high for many cycles gives a single take.
- R9: A request that rises in cycle n, and wins, gives `takeOut` high after the second rising clock edge following that rise. `causeOut` and `vecAddr` hold their values between takes.
- R10: After reset `takeOut`, `causeOut`, `vecAddr`, the prefix and all offset registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysRstReq | input | 1 | System reset request |
| mcSrc | input | NUM_MC | Machine-check sources |
| maskReq | input | 6 | Maskable requests, bit 0 debug up to bit 5 decrementer |
| maskEn | input | 6 | Enable per maskable source |
| cancelReq | input | 6 | Software clear of a maskable pending bit |
| recovOk | input | 1 | Core has reached a recoverable state |
| prefWe | input | 1 | Write strobe for the prefix register |
| prefData | input | 32 | Prefix write data (bits 31:16 kept) |
| offWe | input | 1 | Write strobe for an offset register |
| offSel | input | 4 | Offset register index to write |
| offData | input | 32 | Offset write data (bits 15:4 kept) |
| takeOut | output | 1 | One-cycle take pulse |
| causeOut | output | 3 | Cause code of the last take |
| vecAddr | output | 32 | Handler address of the last take |

## Verification
The assertions assume that every input is synchronous to `clk` and that register writes do not coincide with a take they should affect. The bench changes inputs only on falling edges. It writes the prefix and offset registers while no source is pending, and it raises cancel lines only after every eligible source has drained. A gating check looks one cycle back at the enables and `recovOk`, so the stimulus keeps those steady across each request-to-take window. The sweep covers every subset of the eight causes with both `recovOk` levels and varied enable and cancel patterns.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int FIRST_MASKABLE = 2;
  localparam int NUM_MASKABLE = 6;
  localparam int NUM_CAUSE = FIRST_MASKABLE + NUM_MASKABLE;
  localparam int CAUSE_W = $clog2(NUM_CAUSE);
  localparam int OFF_IDX_W = 4;
  localparam int NUM_OFF = 1 << OFF_IDX_W;
  localparam int PREF_W = 16;
  localparam int OFF_W = 12;

  localparam logic [CAUSE_W-1:0] CAUSE_RESET = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_MCHK  = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_DBG   = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_CRIT  = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_WDOG  = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_EXT   = 3'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_FIT   = 3'd6;
  localparam logic [CAUSE_W-1:0] CAUSE_DEC   = 3'd7;

  typedef struct packed {
    logic                 grant;
    logic [CAUSE_W-1:0]   cause;
    logic [OFF_IDX_W-1:0] offIdx;
  } arbStrobe_t;

  function automatic logic [OFF_IDX_W-1:0] offsetIndex(input logic [CAUSE_W-1:0] c);
    case (c)
      CAUSE_MCHK: return 4'd1;
      CAUSE_DBG:  return 4'd15;
      CAUSE_CRIT: return 4'd0;
      CAUSE_WDOG: return 4'd12;
      CAUSE_EXT:  return 4'd4;
      CAUSE_FIT:  return 4'd11;
      CAUSE_DEC:  return 4'd10;
      default:    return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/exc_arb_ctrl.sv
module exc_arb_ctrl
  import exc_arb_pkg::*;
#(
  parameter int NUM_MC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sysRstReq,
  input  logic [NUM_MC-1:0]       mcSrc,
  input  logic [NUM_MASKABLE-1:0] maskReq,
  input  logic [NUM_MASKABLE-1:0] maskEn,
  input  logic [NUM_MASKABLE-1:0] cancelReq,
  input  logic                    recovOk,
  output arbStrobe_t              strobe,
  output logic                    takeOut,
  output logic [CAUSE_W-1:0]      causeOut
);
  logic                    rstPrev;
  logic [NUM_MC-1:0]       mcPrev;
  logic [NUM_MASKABLE-1:0] maskPrev;
  logic [NUM_CAUSE-1:0]    pend, riseVec, eligible, grantVec, clrVec;
  logic [CAUSE_W-1:0]      winCause;
  logic                    anyWin;

  always_comb begin
    riseVec[0] = sysRstReq & ~rstPrev;
    riseVec[1] = |(mcSrc & ~mcPrev);
    riseVec[NUM_CAUSE-1:FIRST_MASKABLE] = maskReq & ~maskPrev;
  end

  for (genvar gi = 0; gi < NUM_CAUSE; gi++) begin : g_elig
    if (gi < FIRST_MASKABLE) begin : g_nmi
      assign eligible[gi] = pend[gi];
    end else begin : g_mask
      assign eligible[gi] = pend[gi] & maskEn[gi-FIRST_MASKABLE] & recovOk;
    end
  end

  always_comb begin
    winCause = '0;
    anyWin = 1'b0;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winCause = CAUSE_W'(i);
        anyWin = 1'b1;
      end
    end
    grantVec = anyWin ? (NUM_CAUSE'(1) << winCause) : '0;
    clrVec = grantVec | {cancelReq, {FIRST_MASKABLE{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPrev  <= 1'b0;
      mcPrev   <= '0;
      maskPrev <= '0;
      pend     <= '0;
      takeOut  <= 1'b0;
      causeOut <= '0;
    end else begin
      rstPrev  <= sysRstReq;
      mcPrev   <= mcSrc;
      maskPrev <= maskReq;
      pend     <= (pend & ~clrVec) | riseVec;
      takeOut  <= anyWin;
      if (anyWin) causeOut <= winCause;
    end
  end

  assign strobe = '{grant: anyWin, cause: winCause, offIdx: offsetIndex(winCause)};

  // R1
  reset_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend[0] |=> takeOut && causeOut == CAUSE_RESET);

  // R3
  mchk_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    pend[1] && !pend[0] |=> takeOut && causeOut == CAUSE_MCHK);

  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeOut && causeOut >= CAUSE_DBG |->
      $past(recovOk) && ((($past(maskEn)) >> (causeOut - CAUSE_DBG)) & 6'd1) != 6'd0);

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && (anyWin == (eligible != '0)));

  for (genvar gk = 0; gk < NUM_MASKABLE; gk++) begin : g_cancel_chk
    // R7
    cancel_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      cancelReq[gk] && !riseVec[gk+FIRST_MASKABLE] |=> !pend[gk+FIRST_MASKABLE]);
  end
endmodule

// File: rtl/exc_arb_dp.sv
module exc_arb_dp
  import exc_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobe_t           strobe,
  input  logic                 prefWe,
  input  logic [31:0]          prefData,
  input  logic                 offWe,
  input  logic [OFF_IDX_W-1:0] offSel,
  input  logic [31:0]          offData,
  output logic [31:0]          vecAddr
);
  logic [PREF_W-1:0] prefHi;
  logic [OFF_W-1:0]  offBank [NUM_OFF];
  logic              unusedBits;

  assign unusedBits = ^{prefData[15:0], offData[31:16], offData[3:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prefHi <= '0;
      for (int i = 0; i < NUM_OFF; i++) offBank[i] <= '0;
      vecAddr <= '0;
    end else begin
      if (prefWe) prefHi <= prefData[31:16];
      if (offWe) offBank[offSel] <= offData[15:4];
      if (strobe.grant) begin
        if (strobe.cause == CAUSE_RESET) vecAddr <= '0;
        else vecAddr <= {prefHi, offBank[strobe.offIdx], 4'h0};
      end
    end
  end

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.grant |=> $stable(vecAddr));

  // R1
  reset_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grant && strobe.cause == CAUSE_RESET |=> vecAddr == 32'h0);
endmodule

// File: rtl/async_exc_arbiter.sv
module async_exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int NUM_MC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sysRstReq,
  input  logic [NUM_MC-1:0]       mcSrc,
  input  logic [NUM_MASKABLE-1:0] maskReq,
  input  logic [NUM_MASKABLE-1:0] maskEn,
  input  logic [NUM_MASKABLE-1:0] cancelReq,
  input  logic                    recovOk,
  input  logic                    prefWe,
  input  logic [31:0]             prefData,
  input  logic                    offWe,
  input  logic [OFF_IDX_W-1:0]    offSel,
  input  logic [31:0]             offData,
  output logic                    takeOut,
  output logic [CAUSE_W-1:0]      causeOut,
  output logic [31:0]             vecAddr
);
  arbStrobe_t strobe;

  exc_arb_ctrl #(.NUM_MC(NUM_MC)) u_ctrl (
    .clk(clk), .rstN(rstN), .sysRstReq(sysRstReq), .mcSrc(mcSrc),
    .maskReq(maskReq), .maskEn(maskEn), .cancelReq(cancelReq),
    .recovOk(recovOk), .strobe(strobe), .takeOut(takeOut), .causeOut(causeOut)
  );

  exc_arb_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prefWe(prefWe),
    .prefData(prefData), .offWe(offWe), .offSel(offSel),
    .offData(offData), .vecAddr(vecAddr)
  );
endmodule

// File: tb/async_exc_arbiter_tb.sv
module async_exc_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysRstReq = 1'b0;
  logic [NUM_MC-1:0] mcSrc = '0;
  logic [5:0] maskReq = '0, maskEn = '0, cancelReq = '0;
  logic recovOk = 1'b0;
  logic prefWe = 1'b0, offWe = 1'b0;
  logic [31:0] prefData = '0, offData = '0;
  logic [3:0] offSel = '0;
  logic takeOut;
  logic [2:0] causeOut;
  logic [31:0] vecAddr;

  int nChecks = 0, nFails = 0;
  int nLog = 0;
  int logC [16];
  logic [31:0] logA [16];
  logic [31:0] curPref = '0;

  async_exc_arbiter #(.NUM_MC(NUM_MC)) u_dut (
    .clk(clk), .rstN(rstN), .sysRstReq(sysRstReq), .mcSrc(mcSrc),
    .maskReq(maskReq), .maskEn(maskEn), .cancelReq(cancelReq),
    .recovOk(recovOk), .prefWe(prefWe), .prefData(prefData), .offWe(offWe),
    .offSel(offSel), .offData(offData), .takeOut(takeOut),
    .causeOut(causeOut), .vecAddr(vecAddr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] offVal(input int i);
    return {8'h5A, 8'(i * 7), 4'(i), 8'(i * 29 + 3), 4'hF};
  endfunction

  function automatic int idxOf(input int c);
    case (c)
      1: return 1;
      2: return 15;
      3: return 0;
      4: return 12;
      5: return 4;
      6: return 11;
      7: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] expAddr(input int c, input logic [31:0] pref);
    logic [31:0] o;
    if (c == 0) return 32'h0;
    o = offVal(idxOf(c));
    return {pref[31:16], o[15:4], 4'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic collect(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (takeOut && nLog < 16) begin
        logC[nLog] = int'(causeOut);
        logA[nLog] = vecAddr;
        nLog++;
      end
    end
  endtask

  task automatic compareLog(input string req, input logic [7:0] expSet);
    int k = 0;
    for (int c = 0; c < 8; c++) begin
      if (expSet[c]) begin
        if (k < nLog) begin
          check(req, 32'(logC[k]), 32'(c));
          check("R4", logA[k], expAddr(c, curPref));
        end
        k++;
      end
    end
    check(req, 32'(nLog), 32'(k));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] pat, eligA, remB;
    logic [5:0] en, canc;
    logic rec;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", 32'(takeOut), 32'h0);
    check("R10", 32'(causeOut), 32'h0);
    check("R10", vecAddr, 32'h0);

    // R10: offsets and prefix are zero until written; machine check address is zero
    mcSrc[0] = 1'b1;
    @(negedge clk);
    mcSrc[0] = 1'b0;
    @(negedge clk);
    check("R10", 32'(takeOut), 32'h1);
    check("R10", vecAddr, 32'h0);

    for (int i = 0; i < 16; i++) begin
      offWe = 1'b1; offSel = 4'(i); offData = offVal(i);
      @(negedge clk);
    end
    offWe = 1'b0;

    // R9 latency and hold
    curPref = 32'h1234_ABCD;
    prefWe = 1'b1; prefData = curPref;
    @(negedge clk);
    prefWe = 1'b0; maskEn = 6'h3F; recovOk = 1'b1;
    maskReq[1] = 1'b1;
    @(negedge clk);
    maskReq[1] = 1'b0;
    check("R9", 32'(takeOut), 32'h0);
    @(negedge clk);
    check("R9", 32'(takeOut), 32'h1);
    check("R9", 32'(causeOut), 32'h3);
    check("R4", vecAddr, expAddr(3, curPref));
    @(negedge clk);
    check("R9", 32'(takeOut), 32'h0);
    check("R9", 32'(causeOut), 32'h3);
    check("R9", vecAddr, expAddr(3, curPref));

    // R8 held level gives one take
    nLog = 0;
    maskReq[3] = 1'b1;
    collect(10);
    maskReq[3] = 1'b0;
    collect(3);
    compareLog("R8", 8'b0010_0000);

    // Sweep: every subset of causes, both recovOk levels
    for (int t = 0; t < 512; t++) begin
      pat = t[7:0];
      rec = t[8];
      en = 6'((t * 37) >> 2) ^ 6'(t >> 3);
      canc = 6'((t * 13) >> 1);
      curPref = {16'(t) ^ 16'hA5C3, 16'hFFFF};
      prefWe = 1'b1; prefData = curPref;
      maskEn = en; recovOk = rec;
      @(negedge clk);
      prefWe = 1'b0;
      sysRstReq = pat[0];
      mcSrc[t % NUM_MC] = pat[1];
      maskReq = pat[7:2];
      @(negedge clk);
      sysRstReq = 1'b0; mcSrc = '0; maskReq = '0;
      eligA = pat & {en & {6{rec}}, 2'b11};
      nLog = 0;
      collect(11);
      // R1 R2 R3 R5: eligible set drains in ascending order
      compareLog(pat[0] ? "R1" : (pat[1] ? "R3" : "R5"), eligA);
      cancelReq = canc;
      @(negedge clk);
      cancelReq = '0;
      remB = pat & ~eligA & ~{canc, 2'b00};
      maskEn = 6'h3F; recovOk = 1'b1;
      nLog = 0;
      collect(11);
      // R6 R7: held pending bits taken later, cancelled ones never
      compareLog((canc & pat[7:2] & ~eligA[7:2]) != 0 ? "R7" : "R6", remB);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule